// File: doc/BRIEF.md
# Unified Data-Space Address Decoder

This block sits between a CPU core and the data side of a small 8-bit machine. It splits one 16-bit byte-addressed data space into three back-to-back regions. The bottom of the space reaches the general-purpose register file. The next window reaches the I/O registers. Above that lies the internal data SRAM, which is held inside the block. For the register file and the I/O window, the block raises a select and passes out a region-relative index. The external register storage answers with a byte in the same cycle. SRAM accesses are served from the internal array.

Every read, whatever its region, returns its byte on `rdata` one clock edge after the strobe. The byte then stays there until the next accepted read. The top 32 bytes of SRAM are kept for system use: writes there take effect only while `priv_en` is high. Addresses beyond the end of SRAM belong to no region. A read there returns zero, a write there changes nothing, and either one raises a single-cycle error pulse.

Top module: `dspace_decoder`

## Requirements
- R1: An address from 0x0000 to 0x001F with a strobe raises `gpr_sel`, and `gpr_idx` equals the address bits [4:0].
- R2: An address from 0x0020 to 0x005F with a strobe raises `io_sel`, and `io_idx` equals the address minus 0x20.
- R3: An address from 0x0060 to 0x085F with a strobe raises `sram_sel`. A write stores `wdata` in the internal byte at that address, and a later read of the same address returns it.
- R4: A strobed access inside 0x0000 to 0x085F raises exactly one of `gpr_sel`, `io_sel` and `sram_sel`. No select is high when neither strobe is high, and none is high for an address above 0x085F.
- R5: A read accepted in one cycle puts its byte on `rdata` after the next rising edge. For the register file and I/O regions, that byte is `gpr_rdata` or `io_rdata` as sampled in the strobe cycle. `rdata` keeps its value in every cycle that follows no accepted read.
- R6: A write to 0x0840 to 0x085F with `priv_en` low leaves the stored byte unchanged. With `priv_en` high the write takes effect. Reads of this range behave as for any other SRAM byte.
- R7: A read above 0x085F returns 0x00 on `rdata`. A write above 0x085F changes no SRAM byte, including the byte its low address bits would alias to.
- R8: `err` is high in the cycle after each strobed access above 0x085F, and low after any access inside the mapped space, including a blocked reserved write.
- R9: When `rd_en` and `wr_en` are both high, the access is performed as a write only, and `rdata` is left unchanged.
- R10: Synchronous active-high `rst` clears `rdata` and `err` to zero. SRAM contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Byte address of the access |
| wdata | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| priv_en | input | 1 | Allows writes to the reserved top of SRAM |
| gpr_sel | output | 1 | Register file region selected |
| gpr_idx | output | 5 | Register index inside the register file |
| gpr_rdata | input | 8 | Byte returned by the register file |
| io_sel | output | 1 | I/O window selected |
| io_idx | output | 6 | Register index inside the I/O window |
| io_rdata | input | 8 | Byte returned by the I/O registers |
| sram_sel | output | 1 | Internal SRAM selected |
| rdata | output | 8 | Registered read byte |
| err | output | 1 | One-cycle pulse after an access to unmapped space |

## Verification
The decode is tried with addresses on both edges of every region boundary: 0x001F/0x0020, 0x005F/0x0060, 0x083F/0x0840 and 0x085F/0x0860. An off-by-one compare or a wrong offset base therefore shows up as a wrong select or index. Reserved bytes are written once with privilege and once without, and then read back. This tells a working write gate from a missing or inverted one. A write just above the map is followed by a read of the SRAM byte that its truncated offset would hit, which exposes a region test that relies on truncated bits. Reads with no strobe, with both strobes together, and after idle cycles separate a held read byte from one that is updated on every edge.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_GPR  = 2'd1,
        RGN_IO   = 2'd2,
        RGN_SRAM = 2'd3
    } region_e;

    typedef struct packed {
        region_e rgn;
        logic    rsvd;
    } hit_t;

    function automatic logic in_span(
        input logic [31:0] a,
        input logic [31:0] lo,
        input logic [31:0] hi
    );
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/dsd_region_decode.sv
module dsd_region_decode
    import dsd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int GPR_CNT    = 32,
    parameter int IO_CNT     = 64,
    parameter int SRAM_BYTES = 2048,
    parameter int RSVD_BYTES = 32
) (
    input  logic [ADDR_W-1:0]             addr,
    output hit_t                          hit,
    output logic [$clog2(GPR_CNT)-1:0]    gpr_ofs,
    output logic [$clog2(IO_CNT)-1:0]     io_ofs,
    output logic [$clog2(SRAM_BYTES)-1:0] sram_ofs
);
    localparam int GPR_W  = $clog2(GPR_CNT);
    localparam int IO_W   = $clog2(IO_CNT);
    localparam int SRAM_W = $clog2(SRAM_BYTES);

    localparam logic [31:0] GPR_LO  = 32'd0;
    localparam logic [31:0] GPR_HI  = 32'(GPR_CNT - 1);
    localparam logic [31:0] IO_LO   = 32'(GPR_CNT);
    localparam logic [31:0] IO_HI   = 32'(GPR_CNT + IO_CNT - 1);
    localparam logic [31:0] SRAM_LO = 32'(GPR_CNT + IO_CNT);
    localparam logic [31:0] SRAM_HI = 32'(GPR_CNT + IO_CNT + SRAM_BYTES - 1);
    localparam logic [31:0] RSVD_LO = 32'(GPR_CNT + IO_CNT + SRAM_BYTES - RSVD_BYTES);

    logic [31:0] a32;

    always_comb begin
        a32      = 32'(addr);
        hit.rgn  = RGN_NONE;
        hit.rsvd = 1'b0;
        if (in_span(a32, GPR_LO, GPR_HI)) begin
            hit.rgn = RGN_GPR;
        end else if (in_span(a32, IO_LO, IO_HI)) begin
            hit.rgn = RGN_IO;
        end else if (in_span(a32, SRAM_LO, SRAM_HI)) begin
            hit.rgn  = RGN_SRAM;
            hit.rsvd = in_span(a32, RSVD_LO, SRAM_HI);
        end
    end

    assign gpr_ofs  = GPR_W'(addr);
    assign io_ofs   = IO_W'(addr - ADDR_W'(IO_LO));
    assign sram_ofs = SRAM_W'(addr - ADDR_W'(SRAM_LO));

endmodule

// File: rtl/dsd_sram_bank.sv
module dsd_sram_bank #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel,
    input  logic                     wr,
    input  logic                     rd,
    input  logic                     rsvd,
    input  logic                     priv,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata_q
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_ok;
    logic              rd_ok;

    assign wr_ok = sel && wr && (!rsvd || priv);
    assign rd_ok = sel && rd && !wr;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[idx] <= wdata;
        end
        if (rd_ok) begin
            rdata_q <= mem[idx];
        end
    end

    // Checker state: records a blocked reserved write for the next cycle
    logic              blk_q;
    logic [IDX_W-1:0]  blk_idx_q;
    logic [DATA_W-1:0] blk_old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= 1'b0;
        end else begin
            blk_q <= sel && wr && rsvd && !priv;
        end
        blk_idx_q <= idx;
        blk_old_q <= mem[idx];
    end

    // R6
    rsvd_guard_chk: assert property (@(posedge clk) disable iff (rst)
        blk_q |-> (mem[blk_idx_q] == blk_old_q));

endmodule

// File: rtl/dsd_return_path.sv
module dsd_return_path
    import dsd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              rd_go,
    input  region_e           rgn,
    input  logic [DATA_W-1:0] gpr_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] sram_q,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    region_e           src_q;
    logic [DATA_W-1:0] ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= RGN_NONE;
            ext_q <= '0;
            err   <= 1'b0;
        end else begin
            err <= act && (rgn == RGN_NONE);
            if (rd_go) begin
                src_q <= rgn;
                if (rgn == RGN_GPR) begin
                    ext_q <= gpr_rdata;
                end else if (rgn == RGN_IO) begin
                    ext_q <= io_rdata;
                end
            end
        end
    end

    always_comb begin
        unique case (src_q)
            RGN_GPR, RGN_IO: rdata = ext_q;
            RGN_SRAM:        rdata = sram_q;
            default:         rdata = '0;
        endcase
    end

endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int GPR_CNT    = 32,
    parameter int IO_CNT     = 64,
    parameter int SRAM_BYTES = 2048,
    parameter int RSVD_BYTES = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic                       priv_en,
    output logic                       gpr_sel,
    output logic [$clog2(GPR_CNT)-1:0] gpr_idx,
    input  logic [DATA_W-1:0]          gpr_rdata,
    output logic                       io_sel,
    output logic [$clog2(IO_CNT)-1:0]  io_idx,
    input  logic [DATA_W-1:0]          io_rdata,
    output logic                       sram_sel,
    output logic [DATA_W-1:0]          rdata,
    output logic                       err
);
    localparam int SRAM_W = $clog2(SRAM_BYTES);

    hit_t              hit;
    logic [SRAM_W-1:0] sram_ofs;
    logic [DATA_W-1:0] sram_q;
    logic              act;
    logic              rd_go;

    assign act   = rd_en || wr_en;
    assign rd_go = rd_en && !wr_en;

    dsd_region_decode #(
        .ADDR_W    (ADDR_W),
        .GPR_CNT   (GPR_CNT),
        .IO_CNT    (IO_CNT),
        .SRAM_BYTES(SRAM_BYTES),
        .RSVD_BYTES(RSVD_BYTES)
    ) u_decode (
        .addr    (addr),
        .hit     (hit),
        .gpr_ofs (gpr_idx),
        .io_ofs  (io_idx),
        .sram_ofs(sram_ofs)
    );

    assign gpr_sel  = act && (hit.rgn == RGN_GPR);
    assign io_sel   = act && (hit.rgn == RGN_IO);
    assign sram_sel = act && (hit.rgn == RGN_SRAM);

    dsd_sram_bank #(
        .DEPTH (SRAM_BYTES),
        .DATA_W(DATA_W)
    ) u_sram (
        .clk    (clk),
        .rst    (rst),
        .sel    (sram_sel),
        .wr     (wr_en),
        .rd     (rd_en),
        .rsvd   (hit.rsvd),
        .priv   (priv_en),
        .idx    (sram_ofs),
        .wdata  (wdata),
        .rdata_q(sram_q)
    );

    dsd_return_path #(
        .DATA_W(DATA_W)
    ) u_ret (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .rd_go    (rd_go),
        .rgn      (hit.rgn),
        .gpr_rdata(gpr_rdata),
        .io_rdata (io_rdata),
        .sram_q   (sram_q),
        .rdata    (rdata),
        .err      (err)
    );

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gpr_sel, io_sel, sram_sel}));

    // R4
    idle_nosel_chk: assert property (@(posedge clk) disable iff (rst)
        !act |-> !(gpr_sel || io_sel || sram_sel));

    // R8
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(act) && !$past(gpr_sel || io_sel || sram_sel)));

    // R7
    oor_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_go && hit.rgn == RGN_NONE) |=> (rdata == '0));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(rdata));

endmodule

// File: tb/test_dspace_decoder.sv
module test_dspace_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        priv_en = 1'b0;
    logic        gpr_sel, io_sel, sram_sel, err;
    logic [4:0]  gpr_idx;
    logic [5:0]  io_idx;
    logic [7:0]  gpr_rdata, io_rdata, rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // External register models answer combinationally from the index
    assign gpr_rdata = 8'hA0 ^ {3'b000, gpr_idx};
    assign io_rdata  = 8'h40 + {2'b00, io_idx};

    dspace_decoder i_dspace_decoder (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .priv_en  (priv_en),
        .gpr_sel  (gpr_sel),
        .gpr_idx  (gpr_idx),
        .gpr_rdata(gpr_rdata),
        .io_sel   (io_sel),
        .io_idx   (io_idx),
        .io_rdata (io_rdata),
        .sram_sel (sram_sel),
        .rdata    (rdata),
        .err      (err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one access at the falling edge; selects are checked before
    // the rising edge, rdata/err just after it. Strobes drop afterwards.
    task automatic access(input logic [15:0] a, input logic [7:0] d,
                          input logic r, input logic w, input logic p,
                          input logic [2:0] exp_sel, input string req);
        @(negedge clk);
        addr = a; wdata = d; rd_en = r; wr_en = w; priv_en = p;
        #1;
        chk(req, "selects {gpr,io,sram}", {29'd0, gpr_sel, io_sel, sram_sel}, {29'd0, exp_sel});
        @(posedge clk);
        #1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; priv_en = 1'b0;
    endtask

    task automatic read_expect(input logic [15:0] a, input logic [2:0] exp_sel,
                               input logic [7:0] exp_d, input string req);
        access(a, 8'h00, 1'b1, 1'b0, 1'b0, exp_sel, req);
        chk(req, "rdata", {24'd0, rdata}, {24'd0, exp_d});
    endtask

    task automatic t_reset;
        chk("R10", "rdata after reset", {24'd0, rdata}, 32'd0);
        chk("R10", "err after reset", {31'd0, err}, 32'd0);
        chk("R4", "no select at reset", {29'd0, gpr_sel, io_sel, sram_sel}, 32'd0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        addr = 16'h0010; #1;
        chk("R4", "idle gpr addr", {29'd0, gpr_sel, io_sel, sram_sel}, 32'd0);
        addr = 16'h0100; #1;
        chk("R4", "idle sram addr", {29'd0, gpr_sel, io_sel, sram_sel}, 32'd0);
    endtask

    task automatic t_gpr;
        access(16'h0000, 8'h00, 1'b1, 1'b0, 1'b0, 3'b100, "R1");
        chk("R5", "gpr r0 data", {24'd0, rdata}, 32'hA0);
        @(negedge clk);
        addr = 16'h001F; rd_en = 1'b1; #1;
        chk("R1", "gpr_idx at 0x1F", {27'd0, gpr_idx}, 32'd31);
        rd_en = 1'b0;
        read_expect(16'h001F, 3'b100, 8'hBF, "R1");
    endtask

    task automatic t_io;
        @(negedge clk);
        addr = 16'h0020; rd_en = 1'b1; #1;
        chk("R2", "io_idx at 0x20", {26'd0, io_idx}, 32'd0);
        addr = 16'h005F; #1;
        chk("R2", "io_idx at 0x5F", {26'd0, io_idx}, 32'd63);
        rd_en = 1'b0;
        read_expect(16'h0020, 3'b010, 8'h40, "R2");
        read_expect(16'h005F, 3'b010, 8'h7F, "R5");
        chk("R8", "no err after io read", {31'd0, err}, 32'd0);
    endtask

    task automatic t_sram;
        access(16'h0060, 8'h11, 1'b0, 1'b1, 1'b0, 3'b001, "R3");
        access(16'h083F, 8'h5C, 1'b0, 1'b1, 1'b0, 3'b001, "R3");
        read_expect(16'h0060, 3'b001, 8'h11, "R3");
        read_expect(16'h083F, 3'b001, 8'h5C, "R3");
        @(negedge clk);
        @(negedge clk);
        chk("R5", "rdata held over idle cycles", {24'd0, rdata}, 32'h5C);
    endtask

    task automatic t_reserved;
        access(16'h0840, 8'h55, 1'b0, 1'b1, 1'b1, 3'b001, "R6");
        access(16'h0840, 8'hAA, 1'b0, 1'b1, 1'b0, 3'b001, "R6");
        chk("R8", "no err on blocked write", {31'd0, err}, 32'd0);
        read_expect(16'h0840, 3'b001, 8'h55, "R6");
        access(16'h085F, 8'h3C, 1'b0, 1'b1, 1'b1, 3'b001, "R6");
        access(16'h085F, 8'hC3, 1'b0, 1'b1, 1'b0, 3'b001, "R6");
        read_expect(16'h085F, 3'b001, 8'h3C, "R6");
    endtask

    task automatic t_unmapped;
        read_expect(16'h0860, 3'b000, 8'h00, "R7");
        chk("R8", "err after read 0x0860", {31'd0, err}, 32'd1);
        @(negedge clk);
        chk("R8", "err dropped after one cycle", {31'd0, err}, 32'd0);
        access(16'h0860, 8'hEE, 1'b0, 1'b1, 1'b0, 3'b000, "R7");
        chk("R8", "err after write 0x0860", {31'd0, err}, 32'd1);
        read_expect(16'h0060, 3'b001, 8'h11, "R7");
        chk("R8", "no err after mapped read", {31'd0, err}, 32'd0);
        read_expect(16'hFFFF, 3'b000, 8'h00, "R7");
        chk("R8", "err after read 0xFFFF", {31'd0, err}, 32'd1);
    endtask

    task automatic t_both;
        access(16'h0061, 8'h22, 1'b0, 1'b1, 1'b0, 3'b001, "R3");
        read_expect(16'h0061, 3'b001, 8'h22, "R3");
        access(16'h0062, 8'h33, 1'b1, 1'b1, 1'b0, 3'b001, "R9");
        chk("R9", "rdata unchanged on read+write", {24'd0, rdata}, 32'h22);
        read_expect(16'h0062, 3'b001, 8'h33, "R9");
        access(16'h0005, 8'h00, 1'b1, 1'b1, 1'b0, 3'b100, "R9");
        chk("R9", "gpr read+write leaves rdata", {24'd0, rdata}, 32'h33);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_idle();
        t_gpr();
        t_io();
        t_sram();
        t_reserved();
        t_unmapped();
        t_both();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule